// File: doc/BRIEF.md
# Complementary Configuration Pair Checker

This block holds a device's configuration words. A loader writes them one word per cycle from nonvolatile storage. Each word goes into a working register, and its bitwise inverse goes into a background shadow register. Every configuration bit therefore lives as a true/inverse pair.

When the loader closes a load sequence, the block walks the pairs one word per clock. A pair whose two bits agree (both 0 or both 1) is a fault. On a fault the block emits a one-cycle mismatch pulse, which the reset controller uses as a device reset request, and it sets a sticky status flag. A clean walk ends in a one-cycle pass strobe.

The check runs after every load sequence, in every operating mode, including loads made in low-power states. A load sequence may rewrite only some of the words, or none of them. A test input can invert one shadow bit, so that the fault path can be exercised.

Top module: `cfg_pair_checker`

## Requirements
- R1: After reset, cfg_o is all zeros, the shadow words are all ones, and check_ok_o, mismatch_o and cm_flag_o are 0.
- R2: Between seq_start_i (accepted while idle) and seq_end_i, a cycle with ld_valid_i high writes ld_data_i to word ld_idx_i of cfg_o, at bit offset ld_idx_i*WORD_W, and is visible the next cycle. The same write stores the inverse in that word's shadow.
- R3: ld_valid_i outside a load sequence has no effect on cfg_o or on the shadow words.
- R4: After the clock edge that samples seq_end_i, word k is compared at the (k+1)-th following edge. With no faulty pair, check_ok_o pulses for exactly one cycle after edge NUM_WORDS, and mismatch_o stays low.
- R5: If word k holds a faulty pair, mismatch_o pulses for exactly one cycle after edge k+1. Checking stops there, and check_ok_o does not pulse.
- R6: Both kinds of agreeing pair are faults: working and shadow both 1, and working and shadow both 0.
- R7: cm_flag_o sets in the same cycle as mismatch_o and stays set until clr_status_i is high at an edge.
- R8: fault_inj_i high while idle inverts shadow bit fault_bit_i of word fault_word_i. It is ignored during a load sequence and during checking.
- R9: Every load sequence is checked again. A sequence that rewrites a faulty word passes.
- R10: seq_start_i during checking is ignored. The running check completes unchanged.

Unless R5 stops a check early, every check compares all NUM_WORDS words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seq_start_i | input | 1 | Opens a load sequence (idle only) |
| seq_end_i | input | 1 | Closes the load sequence and starts the check |
| ld_valid_i | input | 1 | Word write strobe |
| ld_idx_i | input | IDX_W | Word index |
| ld_data_i | input | WORD_W | Word value |
| fault_inj_i | input | 1 | Test: invert one shadow bit |
| fault_word_i | input | IDX_W | Test: word to corrupt |
| fault_bit_i | input | BIT_W | Test: bit to corrupt |
| clr_status_i | input | 1 | Clears the sticky mismatch flag |
| cfg_o | output | NUM_WORDS*WORD_W | Working configuration, word 0 in the low bits |
| check_ok_o | output | 1 | One-cycle pulse: check passed |
| mismatch_o | output | 1 | One-cycle pulse: faulty pair found |
| cm_flag_o | output | 1 | Sticky mismatch status |

## Verification
The walk is tried in several situations:
- Two full loads with different data patterns show that clean pairs never trip the check.
- An empty load sequence straight after reset shows that the reset values are a consistent pair set.
- Faults injected into the first word, a middle word and the last word separate the per-word timing of the walk. The cycle of each pulse is counted.
- Faults on a bit loaded as 1 and on a bit loaded as 0 show that both agreeing-pair kinds are caught.
- Stray strobes show that writes, fault injections and restarts made outside their window leave the result unchanged:
  - writes while idle,
  - an injection inside a load,
  - a restart during a check.

// File: rtl/cfg_pair_pkg.sv
package cfg_pair_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CHECK = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cfg_word_bank.sv
module cfg_word_bank #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned BIT_W     = 5
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  logic [WORD_W-1:0]                    wr_data_i,
  input  logic                                 flt_en_i,
  input  logic [IDX_W-1:0]                     flt_word_i,
  input  logic [BIT_W-1:0]                     flt_bit_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]     work_o,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]     shadow_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] work_q, shadow_q;
    logic              hit_wr, hit_flt;

    assign hit_wr  = wr_en_i  && (wr_idx_i   == IDX_W'(w));
    assign hit_flt = flt_en_i && (flt_word_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        work_q   <= '0;
        shadow_q <= '1;
      end else if (hit_wr) begin
        work_q   <= wr_data_i;
        shadow_q <= ~wr_data_i;
      end else if (hit_flt) begin
        shadow_q[flt_bit_i] <= ~shadow_q[flt_bit_i];
      end
    end

    assign work_o[w]   = work_q;
    assign shadow_o[w] = shadow_q;
  end
endmodule

// File: rtl/cfg_pair_cmp.sv
module cfg_pair_cmp #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] work_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_i,
  input  logic [IDX_W-1:0]                 sel_i,
  output logic                             bad_o
);
  logic [WORD_W-1:0] w_sel, s_sel;

  always_comb begin
    w_sel = '0;
    s_sel = '1;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (sel_i == IDX_W'(i)) begin
        w_sel = work_i[i];
        s_sel = shadow_i[i];
      end
    end
  end

  // a pair is healthy only when its two bits differ
  assign bad_o = |(~(w_sel ^ s_sel));
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_pair_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_start_i,
  input  logic             seq_end_i,
  input  logic             bad_i,
  input  logic             clr_status_i,
  output logic             load_en_o,
  output logic             idle_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             ok_o,
  output logic             mismatch_o,
  output logic             flag_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;
  logic             ok_q, mm_q, flag_q;
  logic             hit_bad;

  assign hit_bad = (state_q == ST_CHECK) && bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      ok_q    <= 1'b0;
      mm_q    <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      mm_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (seq_start_i) state_q <= ST_LOAD;
        ST_LOAD:  if (seq_end_i) begin
                    state_q <= ST_CHECK;
                    ptr_q   <= '0;
                  end
        ST_CHECK: begin
          if (bad_i) begin
            mm_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (ptr_q == LAST) begin
            ok_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flag_q <= 1'b0;
    else if (hit_bad)      flag_q <= 1'b1;
    else if (clr_status_i) flag_q <= 1'b0;
  end

  assign load_en_o  = (state_q == ST_LOAD);
  assign idle_o     = (state_q == ST_IDLE);
  assign ptr_o      = ptr_q;
  assign ok_o       = ok_q;
  assign mismatch_o = mm_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/cfg_pair_checker.sv
module cfg_pair_checker #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        seq_start_i,
  input  logic                        seq_end_i,
  input  logic                        ld_valid_i,
  input  logic [IDX_W-1:0]            ld_idx_i,
  input  logic [WORD_W-1:0]           ld_data_i,
  input  logic                        fault_inj_i,
  input  logic [IDX_W-1:0]            fault_word_i,
  input  logic [BIT_W-1:0]            fault_bit_i,
  input  logic                        clr_status_i,
  output logic [NUM_WORDS*WORD_W-1:0] cfg_o,
  output logic                        check_ok_o,
  output logic                        mismatch_o,
  output logic                        cm_flag_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] work, shadow;
  logic             load_en, idle, bad;
  logic [IDX_W-1:0] ptr;

  cfg_seq_ctrl #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .seq_start_i, .seq_end_i,
    .bad_i(bad), .clr_status_i,
    .load_en_o(load_en), .idle_o(idle), .ptr_o(ptr),
    .ok_o(check_ok_o), .mismatch_o(mismatch_o), .flag_o(cm_flag_o)
  );

  cfg_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(ld_valid_i && load_en), .wr_idx_i(ld_idx_i), .wr_data_i(ld_data_i),
    .flt_en_i(fault_inj_i && idle), .flt_word_i(fault_word_i), .flt_bit_i(fault_bit_i),
    .work_o(work), .shadow_o(shadow)
  );

  cfg_pair_cmp #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_cmp (
    .work_i(work), .shadow_i(shadow), .sel_i(ptr), .bad_o(bad)
  );

  assign cfg_o = work;
endmodule

// File: rtl/cfg_pair_checker_sva.sv
module cfg_pair_checker_sva #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ld_valid_i,
  input logic                        clr_status_i,
  input logic [NUM_WORDS*WORD_W-1:0] cfg_o,
  input logic                        check_ok_o,
  input logic                        mismatch_o,
  input logic                        cm_flag_o
);
  a_r5_mismatch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> !mismatch_o);
  a_r4_ok_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_ok_o |=> !check_ok_o);
  a_r5_no_ok_with_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(check_ok_o && mismatch_o));
  a_r7_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> cm_flag_o);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_flag_o && !clr_status_i) |=> cm_flag_o);
  a_r3_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> $stable(cfg_o));
endmodule

bind cfg_pair_checker cfg_pair_checker_sva #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .clr_status_i(clr_status_i),
  .cfg_o(cfg_o), .check_ok_o(check_ok_o), .mismatch_o(mismatch_o), .cm_flag_o(cm_flag_o)
);

// File: tb/cfg_pair_checker_test.sv
`timescale 1ns/1ps
module cfg_pair_checker_test;
  localparam int N = 8;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_start = 0, seq_end = 0, ld_valid = 0, fault_inj = 0, clr = 0;
  logic [2:0] ld_idx = '0, fault_word = '0;
  logic [4:0] fault_bit = '0;
  logic [W-1:0] ld_data = '0;
  logic [N*W-1:0] cfg;
  logic ok, mm, flag;
  int n_chk = 0, n_fail = 0;
  logic [W-1:0] model [N];

  always #2 clk = ~clk;

  cfg_pair_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .seq_start_i(seq_start), .seq_end_i(seq_end),
    .ld_valid_i(ld_valid), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .fault_inj_i(fault_inj), .fault_word_i(fault_word), .fault_bit_i(fault_bit),
    .clr_status_i(clr), .cfg_o(cfg), .check_ok_o(ok), .mismatch_o(mm), .cm_flag_o(flag)
  );

  task automatic chk(input bit good, input string req, input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int seed, input int w);
    return W'(32'h9E3779B9 * (w + 1) ^ seed);
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic start_seq(); seq_start = 1; cyc(); seq_start = 0; endtask

  task automatic write_word(input int w, input logic [W-1:0] d);
    ld_valid = 1; ld_idx = 3'(w); ld_data = d; cyc(); ld_valid = 0;
  endtask

  // closes the sequence; returns negedge index of first ok/mm and pulse widths
  task automatic run_check(output int ok_at, output int mm_at, output int ok_n, output int mm_n,
                           input bit restart_mid);
    ok_at = 0; mm_at = 0; ok_n = 0; mm_n = 0;
    seq_end = 1;
    for (int c = 1; c <= N + 4; c++) begin
      cyc();
      seq_end = 0;
      seq_start = (restart_mid && c == 3);
      if (ok) begin ok_n++; if (ok_at == 0) ok_at = c; end
      if (mm) begin mm_n++; if (mm_at == 0) mm_at = c; end
    end
    seq_start = 0;
  endtask

  task automatic inject(input int w, input int b);
    fault_inj = 1; fault_word = 3'(w); fault_bit = 5'(b); cyc(); fault_inj = 0;
  endtask

  task automatic full_load(input int seed, input string req);
    int oa, ma, on, mn;
    start_seq();
    for (int w = 0; w < N; w++) begin model[w] = pat(seed, w); write_word(w, model[w]); end
    for (int w = 0; w < N; w++) chk(cfg[w*W +: W] == model[w], "R2", cfg[w*W +: W], model[w]);
    run_check(oa, ma, on, mn, 1'b0);
    chk(oa == N + 1 && on == 1, req, oa, N + 1);
    chk(mn == 0, req, mn, 0);
  endtask

  task automatic t_reset();
    int oa, ma, on, mn;
    chk(cfg == '0, "R1", cfg[63:0], 0);
    chk({ok, mm, flag} == 3'b000, "R1", {ok, mm, flag}, 0);
    start_seq();
    run_check(oa, ma, on, mn, 1'b0);
    chk(oa == N + 1 && mn == 0, "R1", oa, N + 1);
  endtask

  task automatic t_fault(input int w, input int b, input string req);
    int oa, ma, on, mn;
    inject(w, b);
    start_seq();
    run_check(oa, ma, on, mn, 1'b0);
    chk(ma == w + 2, req, ma, w + 2);
    chk(mn == 1 && on == 0, "R5", {mn, on}, 1);
    chk(flag == 1'b1, "R7", flag, 1);
  endtask

  task automatic t_fault_kinds();
    int b1 = -1, b0 = -1;
    for (int b = 0; b < W; b++) begin
      if (model[4][b] && b1 < 0) b1 = b;
      if (!model[4][b] && b0 < 0) b0 = b;
    end
    t_fault(4, b1, "R6");
    write_word_reload(4);
    t_fault(4, b0, "R6");
    write_word_reload(4);
  endtask

  // reload one word and expect a clean pass (R9)
  task automatic write_word_reload(input int w);
    int oa, ma, on, mn;
    start_seq();
    write_word(w, model[w]);
    run_check(oa, ma, on, mn, 1'b0);
    chk(oa == N + 1 && mn == 0, "R9", oa, N + 1);
  endtask

  task automatic t_flag_clear();
    cyc();
    chk(flag == 1'b1, "R7", flag, 1);
    clr = 1; cyc(); clr = 0;
    chk(flag == 1'b0, "R7", flag, 0);
  endtask

  task automatic t_ignore_valid();
    int oa, ma, on, mn;
    write_word(2, ~model[2]);
    cyc();
    chk(cfg[2*W +: W] == model[2], "R3", cfg[2*W +: W], model[2]);
    start_seq();
    run_check(oa, ma, on, mn, 1'b0);
    chk(oa == N + 1 && mn == 0, "R3", oa, N + 1);
  endtask

  task automatic t_inject_in_load();
    int oa, ma, on, mn;
    start_seq();
    inject(5, 7);
    run_check(oa, ma, on, mn, 1'b0);
    chk(oa == N + 1 && mn == 0, "R8", oa, N + 1);
  endtask

  task automatic t_restart_in_check();
    int oa, ma, on, mn;
    start_seq();
    run_check(oa, ma, on, mn, 1'b1);
    chk(oa == N + 1 && on == 1, "R10", oa, N + 1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    full_load(32'h1234_5678, "R4");
    full_load(32'hA5A5_5A5A, "R4");
    t_fault(0, 0, "R5");
    write_word_reload(0);
    t_fault(3, 9, "R5");
    write_word_reload(3);
    t_fault(N - 1, W - 1, "R5");
    full_load(32'h0F0F_F0F0, "R9");
    t_flag_clear();
    t_fault_kinds();
    t_ignore_valid();
    t_inject_in_load();
    t_restart_in_check();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule